// File: doc/BRIEF.md
# DRAM Access Strobe Generator

This block turns a single bus-cycle request aimed at a DRAM-backed chip-select region into the pin activity a page-less DRAM expects. It drives a multiplexed row/column address, an active-low row strobe, and one or two column strobes and write strobes. Each access walks a fixed sequence. First comes a row phase, where the row address is shown and RAS falls. Next comes a column phase, where the column address is shown and the column and write strobes fall. The strobes are then held for a fixed number of data cycles. Last comes a precharge cycle, where every strobe is high and a one-cycle completion pulse is raised.

A mode input selects between two strobe styles. In the first, each byte lane has its own column strobe and a single write strobe is shared by both lanes. In the second, a single column strobe is shared and each byte lane has its own write strobe. On an 8-bit external bus the shared-column style is always used, and only lane 0 is active. When the DRAM-space enable is low, the block ignores requests and the address outputs simply mirror the ordinary address bits. A refresh-busy input holds off the start of new accesses.

Top module: `dram_strobe_gen`

## Requirements
- R1: While reset is high, and in the cycle after it, ras_n, cas_n and we_n are all high and done is low.
- R2: While dram_en is low, a request starts no access: ras_n stays high and done stays low. While the block is idle, ma shows {addr[22], addr[20], addr[18], addr[16:8]}, one clock after addr is presented.
- R3: A request that is accepted while idle (req, dram_en high, refresh_busy low at a rising edge) gives, after that edge, ras_n low, cas_n = 2'b11, and ma = {addr[22], addr[20], addr[18], addr[16:8]}.
- R4: One cycle after the row phase, ma carries the column address, and ras_n stays low. The column address is {4'b0, addr[8:1]} when bus16 = 1 and {4'b0, addr[7:0]} when bus16 = 0. The column and write strobes are asserted in the same cycle.
- R5: The column and write strobes stay unchanged for 1 + HOLD_CYC cycles. Then, for exactly one cycle, ras_n = 1, cas_n = 2'b11, we_n = 2'b11 and done = 1. Done is low in the following cycle.
- R6: Two-CAS style (byte_ctl = 1, bus16 = 1): cas_n[i] is low exactly when be[i] = 1. we_n[0] is low on writes (wr = 1), and we_n[1] stays high.
- R7: One-CAS style (byte_ctl = 0, bus16 = 1): cas_n = 2'b10. On writes, we_n[i] is low exactly when be[i] = 1. On reads, we_n = 2'b11. cas_n[1] and we_n[1] are never low together.
- R8: 8-bit bus (bus16 = 0): the one-CAS style is used whatever byte_ctl is, and be is ignored. cas_n = 2'b10, and we_n = 2'b10 on writes or 2'b11 on reads.
- R9: While refresh_busy is high, a pending request is not accepted and ras_n stays high. The first rising edge with refresh_busy low accepts it.
- R10: With req held high continuously, ras_n stays high for exactly two cycles (precharge, then idle) before the next access's row phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request level, sampled while idle |
| addr | input | 24 | Byte address of the access |
| wr | input | 1 | 1 = write, 0 = read |
| be | input | 2 | Byte-lane enables (bit 0 = low lane) |
| bus16 | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| dram_en | input | 1 | DRAM-space enable for the region |
| byte_ctl | input | 1 | 1 = two column strobes, 0 = two write strobes |
| refresh_busy | input | 1 | Blocks acceptance of new accesses |
| ma | output | 12 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes, active low |
| we_n | output | 2 | Write strobes, active low |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupt sequencer state shows up on the very next clock, because every pin is registered from the next state. A skipped row phase makes CAS fall in the same cycle as RAS, or while RAS is high. A miscounted data window moves the precharge cycle and the done pulse by whole cycles. A wrongly latched lane or mode pattern shows up as the wrong cas_n or we_n values in the first column cycle, and those values then persist through the data window. A stale address latch shows up as a wrong column value on ma one cycle after RAS falls.

// File: rtl/dram_sg_pkg.sv
package dram_sg_pkg;
  localparam int ADDR_W     = 24;
  localparam int MA_W       = 12;
  localparam int ROW_BASE   = 8;   // first address bit routed linearly to ma
  localparam int ROW_LIN    = 9;   // count of linearly routed row bits
  localparam int ROW_SPARSE = MA_W - ROW_LIN;  // upper pins taken from every other bit
  localparam int COL_W      = 8;
  localparam int LANES      = 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_DATA = 3'd3,
    ST_PRE  = 3'd4
  } seq_st_t;
endpackage

// File: rtl/dram_sg_addr.sv
module dram_sg_addr
  import dram_sg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              bus16,
  output logic [MA_W-1:0]   row_ma,
  output logic [MA_W-1:0]   col_ma
);
  localparam int SPARSE_BASE = ROW_BASE + ROW_LIN + 1;

  assign row_ma[ROW_LIN-1:0] = addr[ROW_BASE +: ROW_LIN];

  for (genvar i = 0; i < ROW_SPARSE; i++) begin : g_sparse
    assign row_ma[ROW_LIN+i] = addr[SPARSE_BASE + 2*i];
  end

  logic [COL_W-1:0] col_bits;
  assign col_bits = bus16 ? addr[COL_W:1] : addr[COL_W-1:0];
  assign col_ma   = {{(MA_W-COL_W){1'b0}}, col_bits};

  logic addr_unused;
  assign addr_unused = ^{addr[ADDR_W-1], addr[21], addr[19], addr[17]};
endmodule

// File: rtl/dram_sg_lane.sv
module dram_sg_lane
  import dram_sg_pkg::*;
(
  input  logic [LANES-1:0] be,
  input  logic             wr,
  input  logic             bus16,
  input  logic             byte_ctl,
  output logic [LANES-1:0] cas_on,
  output logic [LANES-1:0] we_on
);
  logic [LANES-1:0] lane_en;
  logic             two_cas;

  always_comb begin
    lane_en = bus16 ? be : LANES'(1);
    two_cas = byte_ctl & bus16;
    cas_on  = two_cas ? lane_en : LANES'(1);
    if (!wr)
      we_on = '0;
    else if (two_cas)
      we_on = LANES'(1);
    else
      we_on = lane_en;
  end
endmodule

// File: rtl/dram_sg_seq.sv
module dram_sg_seq
  import dram_sg_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output seq_st_t cur,
  output seq_st_t nxt
);
  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_IDLE: if (start) nxt = ST_ROW;
      ST_ROW:  nxt = ST_COL;
      ST_COL:  nxt = ST_DATA;
      ST_DATA: if (cnt == CNT_LAST) nxt = ST_PRE;
      ST_PRE:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= ST_IDLE;
      cnt <= '0;
    end else begin
      cur <= nxt;
      if (cur == ST_DATA) cnt <= cnt + CNT_W'(1);
      else                cnt <= '0;
    end
  end
endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
  import dram_sg_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [LANES-1:0]  be,
  input  logic              bus16,
  input  logic              dram_en,
  input  logic              byte_ctl,
  input  logic              refresh_busy,
  output logic [MA_W-1:0]   ma,
  output logic              ras_n,
  output logic [LANES-1:0]  cas_n,
  output logic [LANES-1:0]  we_n,
  output logic              done
);
  logic [MA_W-1:0]  row_ma, col_ma, lat_col;
  logic [LANES-1:0] cas_on, we_on, lat_cas, lat_we;
  logic             start;
  seq_st_t          cur, nxt;

  assign start = req & dram_en & ~refresh_busy;

  dram_sg_addr u_addr (
    .addr   (addr),
    .bus16  (bus16),
    .row_ma (row_ma),
    .col_ma (col_ma)
  );

  dram_sg_lane u_lane (
    .be       (be),
    .wr       (wr),
    .bus16    (bus16),
    .byte_ctl (byte_ctl),
    .cas_on   (cas_on),
    .we_on    (we_on)
  );

  dram_sg_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .cur   (cur),
    .nxt   (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_col <= '0;
      lat_cas <= '0;
      lat_we  <= '0;
    end else if (cur == ST_IDLE && start) begin
      lat_col <= col_ma;
      lat_cas <= cas_on;
      lat_we  <= we_on;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ma    <= '0;
      ras_n <= 1'b1;
      cas_n <= '1;
      we_n  <= '1;
      done  <= 1'b0;
    end else begin
      done <= (nxt == ST_PRE);
      unique case (nxt)
        ST_IDLE: begin
          ma    <= row_ma;
          ras_n <= 1'b1;
          cas_n <= '1;
          we_n  <= '1;
        end
        ST_ROW: begin
          ma    <= row_ma;
          ras_n <= 1'b0;
          cas_n <= '1;
          we_n  <= '1;
        end
        ST_COL: begin
          ma    <= lat_col;
          ras_n <= 1'b0;
          cas_n <= ~lat_cas;
          we_n  <= ~lat_we;
        end
        ST_DATA: begin
          ras_n <= 1'b0;
        end
        ST_PRE: begin
          ras_n <= 1'b1;
          cas_n <= '1;
          we_n  <= '1;
        end
        default: begin
          ras_n <= 1'b1;
          cas_n <= '1;
          we_n  <= '1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dram_sg_chk.sv
module dram_sg_chk (
  input logic       clk,
  input logic       rst,
  input logic       dram_en,
  input logic       refresh_busy,
  input logic       ras_n,
  input logic [1:0] cas_n,
  input logic [1:0] we_n,
  input logic       done
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (ras_n && cas_n == 2'b11 && we_n == 2'b11 && !done));

  assert_no_start_off_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $past(dram_en));

  assert_row_first_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> cas_n == 2'b11);

  assert_cas_under_ras_R4: assert property (@(posedge clk) disable iff (rst)
    (cas_n != 2'b11) |-> !ras_n);

  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (ras_n && cas_n == 2'b11 && we_n == 2'b11));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_lane1_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(cas_n[1] == 1'b0 && we_n[1] == 1'b0));

  assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> !$past(refresh_busy));
endmodule

bind dram_strobe_gen dram_sg_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .dram_en      (dram_en),
  .refresh_busy (refresh_busy),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n),
  .done         (done)
);

// File: tb/test_dram_strobe_gen.sv
`timescale 1ns/1ps
module test_dram_strobe_gen;
  localparam int HOLD = 2;

  logic        clk = 1'b0;
  logic        rst, req, wr, bus16, dram_en, byte_ctl, refresh_busy;
  logic [23:0] addr;
  logic [1:0]  be;
  logic [11:0] ma;
  logic        ras_n, done;
  logic [1:0]  cas_n, we_n;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dram_strobe_gen #(.HOLD_CYC(HOLD)) i_dram_strobe_gen (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .wr(wr), .be(be),
    .bus16(bus16), .dram_en(dram_en), .byte_ctl(byte_ctl),
    .refresh_busy(refresh_busy), .ma(ma), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .done(done)
  );

  // {addr, wr, be, bus16, byte_ctl, expected cas_n, expected we_n}
  localparam logic [32:0] VECS [7] = '{
    {24'h5A3C7E, 1'b1, 2'b11, 1'b1, 1'b1, 2'b00, 2'b10},
    {24'hA5C381, 1'b0, 2'b01, 1'b1, 1'b1, 2'b10, 2'b11},
    {24'h033333, 1'b1, 2'b10, 1'b1, 1'b1, 2'b01, 2'b10},
    {24'h123456, 1'b1, 2'b10, 1'b1, 1'b0, 2'b10, 2'b01},
    {24'hFEDCBA, 1'b0, 2'b11, 1'b1, 1'b0, 2'b10, 2'b11},
    {24'h0FF00F, 1'b1, 2'b11, 1'b0, 1'b1, 2'b10, 2'b10},
    {24'h8001FF, 1'b0, 2'b10, 1'b0, 1'b0, 2'b10, 2'b11}
  };

  function automatic logic [11:0] row_of(input logic [23:0] a);
    return {a[22], a[20], a[18], a[16:8]};
  endfunction

  function automatic logic [11:0] col_of(input logic [23:0] a, input logic w16);
    return w16 ? {4'b0, a[8:1]} : {4'b0, a[7:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [32:0] v);
    logic [1:0] ec, ew;
    string mtag;
    addr = v[32:9]; wr = v[8]; be = v[7:6]; bus16 = v[5]; byte_ctl = v[4];
    ec = v[3:2]; ew = v[1:0];
    mtag = bus16 ? (byte_ctl ? "R6" : "R7") : "R8";
    dram_en = 1'b1; req = 1'b1;
    cyc();
    req = 1'b0;
    chk(ras_n == 1'b0 && cas_n == 2'b11, "R3 row strobes", {ras_n, cas_n}, 3'b011);
    chk(ma == row_of(addr), "R3 row address", ma, row_of(addr));
    cyc();
    chk(ma == col_of(addr, bus16), "R4 column address", ma, col_of(addr, bus16));
    chk(ras_n == 1'b0, "R4 ras held", ras_n, 0);
    chk(cas_n == ec, {mtag, " cas_n"}, cas_n, ec);
    chk(we_n == ew, {mtag, " we_n"}, we_n, ew);
    for (int k = 0; k < HOLD; k++) begin
      cyc();
      chk(cas_n == ec && we_n == ew && !ras_n, "R5 data hold",
          {ras_n, cas_n, we_n}, {1'b0, ec, ew});
    end
    cyc();
    chk(ras_n && cas_n == 2'b11 && we_n == 2'b11 && done, "R5 precharge",
        {done, ras_n, cas_n, we_n}, 6'h3F);
    cyc();
    chk(!done, "R5 done single", done, 0);
  endtask

  initial begin
    rst = 1'b1; req = 1'b0; wr = 1'b0; bus16 = 1'b1; dram_en = 1'b0;
    byte_ctl = 1'b0; refresh_busy = 1'b0; addr = 24'h0; be = 2'b00;
    repeat (2) cyc();
    chk(ras_n && cas_n == 2'b11 && we_n == 2'b11 && !done, "R1 in reset",
        {done, ras_n, cas_n, we_n}, 6'h1F);
    rst = 1'b0;
    cyc();
    chk(ras_n && cas_n == 2'b11 && we_n == 2'b11 && !done, "R1 after reset",
        {done, ras_n, cas_n, we_n}, 6'h1F);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R2: region not DRAM: request ignored, address passes through
    dram_en = 1'b0; req = 1'b1; addr = 24'hD5AA55; bus16 = 1'b1;
    for (int k = 0; k < 5; k++) begin
      cyc();
      chk(ras_n && !done, "R2 ignored", {ras_n, done}, 2'b10);
    end
    chk(ma == row_of(addr), "R2 pass address", ma, row_of(addr));
    req = 1'b0;

    // R9: refresh busy holds off acceptance
    dram_en = 1'b1; refresh_busy = 1'b1; req = 1'b1; addr = 24'h2468AC;
    wr = 1'b0; be = 2'b11; byte_ctl = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk(ras_n == 1'b1, "R9 blocked", ras_n, 1);
    end
    refresh_busy = 1'b0;
    cyc();
    chk(ras_n == 1'b0, "R9 accepted after busy", ras_n, 0);
    req = 1'b0;
    repeat (HOLD + 4) cyc();

    // R10: back-to-back with req held
    req = 1'b1;
    cyc();
    chk(ras_n == 1'b0, "R10 first row", ras_n, 0);
    repeat (HOLD + 2) cyc();
    chk(ras_n && done, "R10 precharge high", {ras_n, done}, 2'b11);
    cyc();
    chk(ras_n && !done, "R10 idle high", {ras_n, done}, 2'b10);
    cyc();
    chk(ras_n == 1'b0, "R10 next row", ras_n, 0);
    req = 1'b0;
    repeat (HOLD + 4) cyc();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule